// File: doc/BRIEF.md
# Dual-Edge Pixel Lane Deserializer

This block sits behind the differential receivers of a display column driver. It takes nine single-bit data lanes, already at logic level, and a sampling clock. Each lane carries two bits in every clock period: one while the clock is high and one while it is low. The lanes form three groups of three. Each group builds one 6-bit grey code, so every clock period yields one triplet of neighbouring pixel codes.

A start pulse, sampled on the rising edge, marks the first triplet of a line. The block then numbers the triplets from 0 and stops after the line is full. If the start pulse is repeated before data is taken, alignment restarts from the latest pulse. An invert input can flip every bit of each assembled code. All outputs are registered on the rising edge. A one-cycle valid strobe marks each triplet and comes with its index.

Top module: `pxd_deser`

## Requirements
- R1: Lane group g (lanes 3g, 3g+1, 3g+2) forms code g, presented on pixOut[6g+5:6g]. Code 0 belongs to column 3k+1, code 1 to 3k+2 and code 2 to 3k+3, where k is the triplet index.
- R2: Inside group g, lane 3g+j carries code bits 2j (even) and 2j+1 (odd), for j = 0, 1, 2.
- R3: A lane's even bit is the value it holds while the clock is high, taken at the falling edge. Its odd bit is the value it holds while the clock is low, taken at the next rising edge. The assembled triplet appears on the outputs just after that rising edge.
- R4: A start pulse sampled high at a rising edge makes the clock period that begins at that edge the first triplet of a line. Valid is low in the cycle after any edge at which the start pulse is high.
- R5: If the start pulse is high at two consecutive rising edges, the data between them is dropped and the line aligns to the second edge.
- R6: When invertIn is high at the rising edge that completes a triplet, all 18 output bits are the complement of the received bits. When invertIn is low, the bits pass unchanged.
- R7: A line holds 240 triplets. After index 239, valid stays low and lane data is ignored until the next start pulse.
- R8: Valid is high for exactly one clock per triplet. tripIdx counts 0, 1, ... 239, one step per consecutive valid.
- R9: A synchronous active-low reset drops any line in progress and forces valid low. After reset, no triplet is output until a start pulse is seen.
- R10: A start pulse in the middle of a line abandons it. The next triplet is numbered 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; both edges capture lane data |
| rstN | input | 1 | Synchronous active-low reset |
| laneIn | input | 9 | Data lanes; lane 3g+j belongs to group g |
| startIn | input | 1 | Line start pulse, sampled on the rising edge |
| invertIn | input | 1 | Invert assembled codes when high |
| outValid | output | 1 | One-cycle strobe per assembled triplet |
| tripIdx | output | 8 | Triplet index 0 to 239 within the line |
| pixOut | output | 18 | Three 6-bit codes; code g at bits 6g+5:6g |

## Verification
A walking-one and random data set checks the edge and lane-to-bit mapping. A design that swapped the two edges, or mixed up lanes, would show bits moved by one place or across groups. Back-to-back and mid-line start pulses check alignment and renumbering. A wrong design would output the dropped triplet or keep counting from the old index. A full line followed by extra clocks checks the stop after index 239. An off-by-one counter would emit a 241st triplet or stop one short. A reset in mid-line checks that no stale triplet leaks out afterwards. Random invert toggling checks that the flag is taken at the completing edge and not a cycle early or late.

// File: rtl/pxd_pkg.sv
package pxd_pkg;

  // Strobes from the line control to the pixel datapath
  typedef struct packed {
    logic emit;   // capture the triplet completing at this edge
    logic flip;   // complement the triplet being captured
  } pxdStrobe_t;

endpackage

// File: rtl/pxd_ctrl.sv
module pxd_ctrl
  import pxd_pkg::*;
#(
  parameter int TRIPLETS = 240,
  parameter int IDX_W    = $clog2(TRIPLETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             invertIn,
  output pxdStrobe_t       strobe,
  output logic [IDX_W-1:0] slotIdx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(TRIPLETS - 1);

  logic             active;
  logic [IDX_W-1:0] cnt;

  // A start at this edge discards the period now ending (R4, R5, R10)
  always_comb begin
    strobe.emit = active && !startIn;
    strobe.flip = invertIn;
    slotIdx     = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (startIn) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == LAST) begin
        active <= 1'b0;   // line full (R7)
        cnt    <= '0;
      end else begin
        cnt <= cnt + IDX_W'(1);
      end
    end
  end

  // R7: the slot counter never passes the last triplet of a line
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (cnt <= LAST));

  // R9: the cycle after a reset edge has no line in progress
  a_r9_reset_idle: assert property (@(posedge clk)
    !rstN |=> !active);

endmodule

// File: rtl/pxd_datapath.sv
module pxd_datapath
  import pxd_pkg::*;
#(
  parameter int GRPS          = 3,
  parameter int LANES_PER_GRP = 3,
  parameter int IDX_W         = 8,
  localparam int LANES        = GRPS * LANES_PER_GRP,
  localparam int CODE_W       = 2 * LANES_PER_GRP,
  localparam int PIX_W        = GRPS * CODE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] laneIn,
  input  pxdStrobe_t       strobe,
  input  logic [IDX_W-1:0] slotIdx,
  output logic             outValid,
  output logic [IDX_W-1:0] tripIdx,
  output logic [PIX_W-1:0] pixOut
);

  logic [LANES-1:0] fallBits;   // values held during the high phase
  logic [PIX_W-1:0] word;

  // Even bits are taken at mid-period (R3)
  always_ff @(negedge clk) begin
    fallBits <= laneIn;
  end

  // Lane 3g+j -> code g bits 2j and 2j+1 (R1, R2)
  for (genvar g = 0; g < GRPS; g++) begin : gGrp
    for (genvar j = 0; j < LANES_PER_GRP; j++) begin : gLane
      assign word[g*CODE_W + 2*j]     = fallBits[g*LANES_PER_GRP + j];
      assign word[g*CODE_W + 2*j + 1] = laneIn[g*LANES_PER_GRP + j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      tripIdx  <= '0;
      pixOut   <= '0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.emit) begin
        tripIdx <= slotIdx;
        pixOut  <= strobe.flip ? ~word : word;   // R6
      end
    end
  end

  // R8: consecutive triplets carry consecutive indices
  a_r8_idx_step: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> (tripIdx == $past(tripIdx) + IDX_W'(1)));

  // R8: outputs hold still while no triplet is presented
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && $past(rstN)) |-> ($stable(pixOut) && $stable(tripIdx)));

endmodule

// File: rtl/pxd_deser.sv
module pxd_deser
  import pxd_pkg::*;
#(
  parameter int GRPS          = 3,
  parameter int LANES_PER_GRP = 3,
  parameter int TRIPLETS      = 240,
  localparam int LANES        = GRPS * LANES_PER_GRP,
  localparam int CODE_W       = 2 * LANES_PER_GRP,
  localparam int PIX_W        = GRPS * CODE_W,
  localparam int IDX_W        = $clog2(TRIPLETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] laneIn,
  input  logic             startIn,
  input  logic             invertIn,
  output logic             outValid,
  output logic [IDX_W-1:0] tripIdx,
  output logic [PIX_W-1:0] pixOut
);

  pxdStrobe_t       strobe;
  logic [IDX_W-1:0] slotIdx;

  pxd_ctrl #(
    .TRIPLETS (TRIPLETS),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .invertIn (invertIn),
    .strobe   (strobe),
    .slotIdx  (slotIdx)
  );

  pxd_datapath #(
    .GRPS          (GRPS),
    .LANES_PER_GRP (LANES_PER_GRP),
    .IDX_W         (IDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .laneIn   (laneIn),
    .strobe   (strobe),
    .slotIdx  (slotIdx),
    .outValid (outValid),
    .tripIdx  (tripIdx),
    .pixOut   (pixOut)
  );

  // R4: no triplet in the cycle after a sampled start pulse
  a_r4_start_gap: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> !outValid);

  // R7: nothing follows the last triplet of a line
  a_r7_stop_at_end: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && tripIdx == IDX_W'(TRIPLETS - 1)) |=> !outValid);

  // R10: every run of triplets starts at index zero
  a_r10_first_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (tripIdx == '0));

endmodule

// File: tb/pxd_deser_bench.sv
module pxd_deser_bench;

  localparam int NTRIP = 240;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  laneIn = '0;
  logic        startIn = 1'b0;
  logic        invertIn = 1'b0;
  logic        outValid;
  logic [7:0]  tripIdx;
  logic [17:0] pixOut;

  always #5 clk = ~clk;

  pxd_deser u_pxd_deser (
    .clk      (clk),
    .rstN     (rstN),
    .laneIn   (laneIn),
    .startIn  (startIn),
    .invertIn (invertIn),
    .outValid (outValid),
    .tripIdx  (tripIdx),
    .pixOut   (pixOut)
  );

  int          nChk = 0;
  int          nFail = 0;
  bit          mActive = 1'b0;
  int          mCnt = 0;
  logic [17:0] prevD = '0;

  // Lane 3g+j carries bit 6g+2j first and bit 6g+2j+1 second (R1, R2, R3)
  function automatic logic [8:0] evenLanes(logic [17:0] d);
    logic [8:0] r;
    for (int g = 0; g < 3; g++)
      for (int j = 0; j < 3; j++) r[3*g+j] = d[6*g+2*j];
    return r;
  endfunction

  function automatic logic [8:0] oddLanes(logic [17:0] d);
    logic [8:0] r;
    for (int g = 0; g < 3; g++)
      for (int j = 0; j < 3; j++) r[3*g+j] = d[6*g+2*j+1];
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock period. s/inv act at the coming rising edge; d is sent in
  // the period that begins there.
  task automatic step(bit s, bit inv, logic [17:0] d, string tag);
    bit          expV;
    int          expI;
    logic [17:0] expP;
    startIn  = s;
    invertIn = inv;
    @(posedge clk);
    #1;
    laneIn = evenLanes(d);
    expV = rstN && !s && mActive;
    expI = mCnt;
    expP = inv ? ~prevD : prevD;
    if (!rstN) begin
      mActive = 1'b0; mCnt = 0;
    end else if (s) begin
      mActive = 1'b1; mCnt = 0;
    end else if (mActive) begin
      if (mCnt == NTRIP - 1) begin
        mActive = 1'b0; mCnt = 0;
      end else mCnt++;
    end
    #3;
    chk({tag, " valid"}, 32'(outValid), 32'(expV));
    if (expV) begin
      chk({tag, " R8 index"}, 32'(tripIdx), 32'(expI));
      chk({tag, " R1 R2 R3 R6 pixels"}, 32'(pixOut), 32'(expP));
    end
    @(negedge clk);
    #1;
    laneIn = oddLanes(d);
    prevD  = d;
    startIn = 1'b0;
  endtask

  task automatic fillLine(int n, string tag);
    for (int i = 0; i < n; i++)
      step(1'b0, 1'($urandom_range(1)), 18'($urandom), tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R9: held in reset, no output
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 18'h3ffff, "R9 reset");
    rstN = 1'b1;
    // R4: no start seen yet, nothing comes out
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 18'($urandom), "R4 idle");

    // R1 R2 R3: walking one through all 18 bit places, no inversion
    step(1'b1, 1'b0, 18'h00001, "R4 start");
    for (int k = 1; k < 18; k++) step(1'b0, 1'b0, 18'(1) << k, "R2 walk");
    step(1'b0, 1'b0, 18'h3ffff, "R1 ones");
    step(1'b0, 1'b1, 18'h00000, "R6 inv");
    step(1'b0, 1'b1, 18'h2aaaa, "R6 inv");
    // rest of the line with random data and invert; R7 end of line
    fillLine(NTRIP - 20 + 1, "R7 line");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 18'($urandom), "R7 after end");

    // R5: back-to-back start pulses
    step(1'b1, 1'b0, 18'h15555, "R5 first start");
    step(1'b1, 1'b0, 18'h0f0f0, "R5 second start");
    fillLine(12, "R5 aligned");

    // R10: restart in mid-line
    step(1'b1, 1'b0, 18'($urandom), "R10 restart");
    fillLine(8, "R10 renumber");

    // R9: reset in mid-line drops the line
    rstN = 1'b0;
    step(1'b0, 1'b0, 18'($urandom), "R9 mid reset");
    rstN = 1'b1;
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 18'($urandom), "R9 after reset");

    // second full line, ending without a new start (R7, R8)
    step(1'b1, 1'b1, 18'($urandom), "R4 start");
    fillLine(NTRIP + 4, "R7 full line");

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #2_000_000;
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule